// File: doc/BRIEF.md
# Three-Thread Packet Dispatch Scheduler

This block picks, on every clock, which hardware thread may send one instruction packet into a shared execute pipeline. The pipeline is as deep as there are threads. In the fixed rotation mode each thread owns one slot out of every three, so a thread's earlier packet has always left the pipeline before its next one enters, and no interlock is needed. In the dynamic mode the scheduler drops threads that cannot issue and hands their slots to the threads that can. A thread cannot issue while it waits for a cache miss to return, or while it is asleep or switched off. A thread that has just issued must also wait for its packet's minimum latency before it issues again.

Each thread has a small context with three states: running, waiting on a miss, and off (asleep). Requests from the thread side move it between these states. The scheduler grants in round-robin order from a rotation pointer. It also drives a clock enable for each thread, so that a sleeping thread's logic draws no clock power.

Top module: `mt_dispatch_sched`

## Requirements
- R1: After reset, thread 0 is running, threads 1 and 2 are off, `thr_clk_en` is 3'b001 and the rotation pointer names thread 0.
- R2: With `dyn_mode`=0 the owning slot advances 0,1,2,0,... by one thread every clock, whether or not a packet issues. `grant` is one-hot with bit i meaning thread i.
- R3: With `dyn_mode`=0, a slot whose owner is not running or has `pkt_rdy` low gives a bubble (`grant`=0) and is never handed to another thread.
- R4: With `dyn_mode`=1 the grant goes to the first thread at or after the rotation pointer that is running, has `pkt_rdy` high and is past its issue gap. The pointer then moves to the thread after the granted one. With no such thread, `grant` is 0 and the pointer holds.
- R5: `miss_set[i]` on a running thread puts it in the miss state from the next clock, and it gets no grant until `miss_ret[i]` is seen. It is eligible again on the clock after `miss_ret[i]`.
- R6: `sleep_req[i]` on a running or missing thread turns it off from the next clock, and an off thread never gets a grant. `wake[i]` on an off thread makes it running, and it is eligible on the clock after the wake.
- R7: With `dyn_mode`=1 a thread granted in one clock is not granted again within the next DYN_GAP-1 clocks (default 2-clock packets). A lone ready thread therefore issues every other clock.
- R8: `grant` has at most one bit set. `grant_tid` is the index of the set bit, and 0 when there is no grant.
- R9: `thr_clk_en[i]` is high exactly when thread i is running or waiting on a miss, and low when it is off.
- R10: Inputs that do not apply to the present state are ignored. These are `wake` on a running thread, `miss_set` or `miss_ret` on an off thread, and `miss_ret` on a running thread. On a running thread, `sleep_req` takes priority over `miss_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dyn_mode | input | 1 | 0: fixed rotation, 1: dynamic skipping |
| pkt_rdy | input | NUM_THREADS | Thread has a packet to issue |
| miss_set | input | NUM_THREADS | Thread has started waiting on a cache miss |
| miss_ret | input | NUM_THREADS | Miss data for thread has returned |
| sleep_req | input | NUM_THREADS | Thread enters wait-for-interrupt / off |
| wake | input | NUM_THREADS | Interrupt wake for an off thread |
| grant | output | NUM_THREADS | One-hot dispatch grant |
| grant_tid | output | $clog2(NUM_THREADS) | Index of granted thread |
| thr_clk_en | output | NUM_THREADS | Per-thread clock enable |

## Verification
The hardest case to reach is a thread that comes back from a miss while the rotation pointer and the issue-gap counters of the other threads are in a known place. Only then can the exact grant be predicted. To reach it, the bench holds every thread ready in dynamic mode and parks one thread in the miss state for several clocks, so the others alternate over its slot. It then returns the miss and narrows `pkt_rdy` to that thread alone, so that the first grant after the return names it without ambiguity. The sleep, wake and priority cases use the same step: first lead the context into the wanted state, then read it back through `thr_clk_en` and the grant.

// File: rtl/mtd_pkg.sv
package mtd_pkg;

   typedef enum logic [1:0] {
      THR_OFF  = 2'd0,
      THR_RUN  = 2'd1,
      THR_MISS = 2'd2
   } thr_state_e;

   function automatic int wrap_inc(input int v, input int n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction

endpackage

// File: rtl/mtd_thread_ctx.sv
module mtd_thread_ctx
   import mtd_pkg::*;
#(
   parameter bit START_RUN = 1'b0,
   parameter int GAP       = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic miss_set,
   input  logic miss_ret,
   input  logic sleep_req,
   input  logic wake,
   input  logic issued,
   output logic running,
   output logic awake,
   output logic cool_ok
);

   localparam thr_state_e RST_STATE = START_RUN ? THR_RUN : THR_OFF;

   thr_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         THR_OFF: begin
            if (wake) state_d = THR_RUN;
         end
         THR_RUN: begin
            if (sleep_req)     state_d = THR_OFF;
            else if (miss_set) state_d = THR_MISS;
         end
         THR_MISS: begin
            if (sleep_req)     state_d = THR_OFF;
            else if (miss_ret) state_d = THR_RUN;
         end
         default: state_d = THR_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= RST_STATE;
      else        state_q <= state_d;
   end

   assign running = (state_q == THR_RUN);
   assign awake   = (state_q != THR_OFF);

   generate
      if (GAP > 1) begin : g_gap
         localparam int CW = $clog2(GAP);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              cnt_q <= '0;
            else if (issued)         cnt_q <= CW'(GAP - 1);
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign cool_ok = (cnt_q == '0);
      end else begin : g_nogap
         assign cool_ok = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/mtd_rr_pick.sv
module mtd_rr_pick #(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] base,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          vld
);

   always_comb begin
      gnt = '0;
      idx = '0;
      vld = 1'b0;
      for (int i = 0; i < N; i++) begin
         int c;
         c = int'(base) + i;
         if (c >= N) c = c - N;
         if (!vld && req[c]) begin
            vld    = 1'b1;
            idx    = IW'(c);
            gnt[c] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/mtd_rot_ptr.sv
module mtd_rot_ptr
   import mtd_pkg::*;
#(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dyn_mode,
   input  logic          pick_vld,
   input  logic [IW-1:0] pick_idx,
   output logic [IW-1:0] ptr
);

   logic [IW-1:0] ptr_q, ptr_d;

   always_comb begin
      ptr_d = ptr_q;
      if (!dyn_mode)     ptr_d = IW'(wrap_inc(int'(ptr_q), N));
      else if (pick_vld) ptr_d = IW'(wrap_inc(int'(pick_idx), N));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   assign ptr = ptr_q;

endmodule

// File: rtl/mt_dispatch_sched.sv
module mt_dispatch_sched #(
   parameter int NUM_THREADS = 3,
   parameter int DYN_GAP     = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           dyn_mode,
   input  logic [NUM_THREADS-1:0]         pkt_rdy,
   input  logic [NUM_THREADS-1:0]         miss_set,
   input  logic [NUM_THREADS-1:0]         miss_ret,
   input  logic [NUM_THREADS-1:0]         sleep_req,
   input  logic [NUM_THREADS-1:0]         wake,
   output logic [NUM_THREADS-1:0]         grant,
   output logic [$clog2(NUM_THREADS)-1:0] grant_tid,
   output logic [NUM_THREADS-1:0]         thr_clk_en
);

   localparam int TID_W = $clog2(NUM_THREADS);

   generate
      if (NUM_THREADS < 2) begin : g_bad_n
         $error("mt_dispatch_sched: NUM_THREADS must be at least 2");
      end
      if (DYN_GAP < 1 || DYN_GAP > NUM_THREADS) begin : g_bad_gap
         $error("mt_dispatch_sched: DYN_GAP must lie in 1..NUM_THREADS");
      end
   endgenerate

   logic [NUM_THREADS-1:0] run_v, cool_v, elig_ilv, elig_dyn;
   logic [NUM_THREADS-1:0] ilv_grant, dyn_grant;
   logic [TID_W-1:0]       ptr, pick_idx;
   logic                   pick_vld;

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         mtd_thread_ctx #(
            .START_RUN (t == 0),
            .GAP       (DYN_GAP)
         ) u_ctx (
            .clk       (clk),
            .rst_n     (rst_n),
            .miss_set  (miss_set[t]),
            .miss_ret  (miss_ret[t]),
            .sleep_req (sleep_req[t]),
            .wake      (wake[t]),
            .issued    (grant[t]),
            .running   (run_v[t]),
            .awake     (thr_clk_en[t]),
            .cool_ok   (cool_v[t])
         );
         assign elig_ilv[t]  = run_v[t] & pkt_rdy[t];
         assign elig_dyn[t]  = elig_ilv[t] & cool_v[t];
         assign ilv_grant[t] = (ptr == TID_W'(t)) & elig_ilv[t];
      end
   endgenerate

   mtd_rr_pick #(
      .N  (NUM_THREADS),
      .IW (TID_W)
   ) u_pick (
      .req  (elig_dyn),
      .base (ptr),
      .gnt  (dyn_grant),
      .idx  (pick_idx),
      .vld  (pick_vld)
   );

   mtd_rot_ptr #(
      .N  (NUM_THREADS),
      .IW (TID_W)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .dyn_mode (dyn_mode),
      .pick_vld (pick_vld),
      .pick_idx (pick_idx),
      .ptr      (ptr)
   );

   always_comb begin
      if (dyn_mode) begin
         grant     = dyn_grant;
         grant_tid = pick_vld ? pick_idx : '0;
      end else begin
         grant     = ilv_grant;
         grant_tid = (|ilv_grant) ? ptr : '0;
      end
   end

endmodule

// File: rtl/mtd_sched_chk.sv
module mtd_sched_chk #(
   parameter int NUM_THREADS = 3,
   parameter int DYN_GAP     = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           dyn_mode,
   input logic [NUM_THREADS-1:0]         pkt_rdy,
   input logic [NUM_THREADS-1:0]         miss_set,
   input logic [NUM_THREADS-1:0]         miss_ret,
   input logic [NUM_THREADS-1:0]         sleep_req,
   input logic [NUM_THREADS-1:0]         wake,
   input logic [NUM_THREADS-1:0]         grant,
   input logic [$clog2(NUM_THREADS)-1:0] grant_tid,
   input logic [NUM_THREADS-1:0]         thr_clk_en
);

   p_onehot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   p_tid_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant) |-> grant[grant_tid]);

   p_tid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|grant) |-> (grant_tid == '0));

   generate
      for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
         p_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
            grant[t] |-> pkt_rdy[t]);

         p_off_no_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !thr_clk_en[t] |-> !grant[t]);

         p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!thr_clk_en[t] && wake[t]) |=> thr_clk_en[t]);

         p_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_clk_en[t] && sleep_req[t]) |=> !thr_clk_en[t]);

         p_miss_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_clk_en[t] && miss_set[t] && !miss_ret[t]) |=> !grant[t]);

         if (DYN_GAP > 1) begin : g_gap
            p_issue_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
               grant[t] |=> !grant[t]);
         end
      end
   endgenerate

endmodule

bind mt_dispatch_sched mtd_sched_chk #(
   .NUM_THREADS (NUM_THREADS),
   .DYN_GAP     (DYN_GAP)
) u_chk (.*);

// File: tb/mt_dispatch_sched_tb_top.sv
module mt_dispatch_sched_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       dyn_mode;
   logic [2:0] pkt_rdy, miss_set, miss_ret, sleep_req, wake;
   logic [2:0] grant, thr_clk_en;
   logic [1:0] grant_tid;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   mt_dispatch_sched dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .dyn_mode   (dyn_mode),
      .pkt_rdy    (pkt_rdy),
      .miss_set   (miss_set),
      .miss_ret   (miss_ret),
      .sleep_req  (sleep_req),
      .wake       (wake),
      .grant      (grant),
      .grant_tid  (grant_tid),
      .thr_clk_en (thr_clk_en)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_out(input string req, input logic [2:0] eg,
                          input logic [1:0] et, input logic [2:0] ee);
      #1;
      chk(req, "grant", 32'(grant), 32'(eg));
      chk(req, "grant_tid", 32'(grant_tid), 32'(et));
      chk(req, "thr_clk_en", 32'(thr_clk_en), 32'(ee));
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic clear_in();
      pkt_rdy = '0; miss_set = '0; miss_ret = '0; sleep_req = '0; wake = '0;
   endtask

   task automatic reset_dut();
      rst_n = 1'b0;
      dyn_mode = 1'b1;
      clear_in();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
   endtask

   task automatic wake_all();
      dyn_mode = 1'b1;
      clear_in();
      wake = 3'b110;
      tick();
      wake = '0;
   endtask

   task automatic t_reset();
      reset_dut();
      chk_out("R1", 3'b000, 2'd0, 3'b001);
      pkt_rdy = 3'b111;
      dyn_mode = 1'b0;
      chk_out("R1", 3'b001, 2'd0, 3'b001);
   endtask

   task automatic t_rotate();
      reset_dut();
      wake_all();
      dyn_mode = 1'b0;
      pkt_rdy  = 3'b111;
      for (int k = 0; k < 6; k++) begin
         chk_out("R2", 3'(1 << (k % 3)), 2'(k % 3), 3'b111);
         tick();
      end
   endtask

   task automatic t_bubble();
      reset_dut();
      wake_all();
      dyn_mode = 1'b0;
      pkt_rdy  = 3'b101;
      for (int k = 0; k < 3; k++) begin
         if (k == 1) chk_out("R3", 3'b000, 2'd0, 3'b111);
         else        chk_out("R3", 3'(1 << k), 2'(k), 3'b111);
         tick();
      end
   endtask

   task automatic t_dynamic();
      reset_dut();
      wake_all();
      dyn_mode = 1'b1;
      pkt_rdy = 3'b110; chk_out("R4", 3'b010, 2'd1, 3'b111); tick();
      pkt_rdy = 3'b110; chk_out("R4", 3'b100, 2'd2, 3'b111); tick();
      pkt_rdy = 3'b000; chk_out("R4", 3'b000, 2'd0, 3'b111); tick();
      pkt_rdy = 3'b111; chk_out("R4", 3'b001, 2'd0, 3'b111); tick();
      pkt_rdy = 3'b101; chk_out("R4", 3'b100, 2'd2, 3'b111); tick();
   endtask

   task automatic t_gap();
      reset_dut();
      dyn_mode = 1'b1;
      pkt_rdy  = 3'b001;
      for (int k = 0; k < 4; k++) begin
         chk_out("R7", (k % 2 == 0) ? 3'b001 : 3'b000, 2'd0, 3'b001);
         tick();
      end
   endtask

   task automatic t_miss();
      reset_dut();
      wake_all();
      dyn_mode = 1'b1;
      pkt_rdy  = 3'b111;
      miss_set = 3'b001;
      chk_out("R5", 3'b001, 2'd0, 3'b111);
      tick();
      miss_set = '0;
      for (int k = 0; k < 4; k++) begin
         #1;
         chk("R5", "grant[0] during miss", 32'(grant[0]), 32'd0);
         chk("R9", "thr_clk_en during miss", 32'(thr_clk_en), 32'h7);
         tick();
      end
      miss_ret = 3'b001;
      #1;
      chk("R5", "grant[0] on return clock", 32'(grant[0]), 32'd0);
      tick();
      miss_ret = '0;
      pkt_rdy  = 3'b001;
      chk_out("R5", 3'b001, 2'd0, 3'b111);
   endtask

   task automatic t_sleep();
      reset_dut();
      wake_all();
      dyn_mode  = 1'b1;
      sleep_req = 3'b100;
      chk_out("R9", 3'b000, 2'd0, 3'b111);
      tick();
      sleep_req = '0;
      pkt_rdy   = 3'b100;
      chk_out("R6", 3'b000, 2'd0, 3'b011);
      tick();
      wake = 3'b100;
      chk_out("R6", 3'b000, 2'd0, 3'b011);
      tick();
      wake = '0;
      chk_out("R6", 3'b100, 2'd2, 3'b111);
   endtask

   task automatic t_ignored();
      reset_dut();
      dyn_mode = 1'b1;
      miss_ret = 3'b011;
      wake     = 3'b001;
      miss_set = 3'b010;
      tick();
      clear_in();
      pkt_rdy = 3'b011;
      chk_out("R10", 3'b001, 2'd0, 3'b001);
      tick();
      clear_in();
      sleep_req = 3'b001;
      miss_set  = 3'b001;
      tick();
      clear_in();
      chk_out("R10", 3'b000, 2'd0, 3'b000);
      wake = 3'b001;
      tick();
      clear_in();
      pkt_rdy = 3'b001;
      chk_out("R10", 3'b001, 2'd0, 3'b001);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_rotate();
      t_bubble();
      t_dynamic();
      t_gap();
      t_miss();
      t_sleep();
      t_ignored();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule